// File: doc/BRIEF.md
# Command Frame Parser with Negative Acknowledge

This block sits behind a serial slave port that delivers one 16-bit word at a time. It splits the incoming word stream into commands. The first word of each command is a header: a 4-bit opcode in bits 15:12 and a 12-bit length in bits 11:0. The length gives the size of the command in 16-bit words, header included. Each accepted word is passed downstream with start-of-command, end-of-command and opcode markers. The block does not check payload contents, so a wrong length field misframes the stream.

Opcodes are checked against a 16-entry parameter mask. An opcode whose mask bit is clear is not forwarded. The block answers it at once with a negative-acknowledge word. For a supported opcode, the block waits after the last word until downstream logic reports that the command has finished. It then takes over the data line and shifts an acknowledge word back to the host, one bit per host clock strobe. Words that arrive while the block waits or responds are dropped. The next word after a response is read as a new header.

Top module: `cmd_frame_parser`

## Requirements
- R1: A header's opcode comes from bits 15:12 and its length from bits 11:0. A supported header is forwarded with `cmd_sop_o` high, one cycle after it is accepted, and `cmd_opcode_o` equals the header opcode.
- R2: A supported header with a length N of 2 or more forwards exactly N words: the header plus N-1 following words. Only the last of these has `cmd_eop_o` high.
- R3: A length of 0 or 1 makes a header-only command. It is forwarded as one word with `cmd_sop_o` and `cmd_eop_o` both high, and the next word is not read as part of it.
- R4: An opcode whose bit in `SUP_MASK` is 0 produces no downstream word. `sd_oe_o` rises in the cycle after the header is accepted, and the host then shifts out the negative-acknowledge response.
- R5: A response word is {code[7:0], 4'b0000, opcode[3:0]}. The code is `ACK_CODE` (default 8'hA5) for a completed command and `NACK_CODE` (default 8'h5A) for a rejected opcode.
- R6: While `sd_oe_o` is high, `sd_o` shows response bit 15 first. Each `bit_tick_i` pulse advances one bit, and `sd_o` holds between pulses. After the 16th pulse `sd_oe_o` falls.
- R7: After the last word of a supported command, `sd_oe_o` stays low until `exec_done_i` is seen. It rises one cycle after that. An `exec_done_i` pulse at any other time has no effect.
- R8: Words that arrive between the end of a command and the end of its response are discarded. The first word after the response is read as a header.
- R9: After reset, `cmd_valid_o` and `sd_oe_o` are low and the first word is read as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received word strobe |
| rx_word_i | input | 16 | Received word |
| cmd_valid_o | output | 1 | Downstream word valid |
| cmd_word_o | output | 16 | Downstream word |
| cmd_sop_o | output | 1 | Word is a command header |
| cmd_eop_o | output | 1 | Word is the last of its command |
| cmd_opcode_o | output | 4 | Opcode of the current command |
| exec_done_i | input | 1 | Downstream command completion |
| bit_tick_i | input | 1 | Host clock strobe, one per response bit |
| sd_o | output | 1 | Response data bit |
| sd_oe_o | output | 1 | Data line driven by this block |

## Verification
If the remaining-word count is wrong, the error shows up within one command: the end marker lands on the wrong word, and the next header is forwarded as data or a data word as a header. The scoreboard sees this on the very next downstream word. If the state machine is stuck or a wrong state is entered, it shows as a line that turns around too early, before completion is signalled, or that never turns around. The bench checks this at a fixed cycle after each header or completion pulse. Errors in the shift register or the bit counter corrupt the 16-bit word that the bench assembles, or leave the line driven after the 16th strobe.

// File: rtl/cmd_parser_pkg.sv
package cmd_parser_pkg;
  localparam int WORD_W  = 16;
  localparam int OP_W    = 4;
  localparam int LEN_W   = 12;
  localparam int NUM_OPS = 1 << OP_W;
  localparam int CODE_W  = WORD_W - 8;

  typedef enum logic [1:0] {ST_HDR, ST_DATA, ST_WAIT, ST_RESP} frame_st_e;

  function automatic logic [WORD_W-1:0] make_resp(input logic [CODE_W-1:0] code,
                                                  input logic [OP_W-1:0] op);
    return {code, {(8-OP_W){1'b0}}, op};
  endfunction
endpackage

// File: rtl/hdr_decode.sv
module hdr_decode
  import cmd_parser_pkg::*;
#(
  parameter logic [NUM_OPS-1:0] SUP_MASK = 16'h80FE
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [OP_W-1:0]   op_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              sup_o,
  output logic              short_o
);
  assign op_o    = word_i[WORD_W-1 -: OP_W];
  assign len_o   = word_i[LEN_W-1:0];
  assign sup_o   = SUP_MASK[op_o];
  assign short_o = (len_o <= LEN_W'(1));
endmodule

// File: rtl/resp_shifter.sv
module resp_shifter
  import cmd_parser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tick_i,
  output logic              sd_o,
  output logic              oe_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= '0;
      oe_q  <= 1'b1;
    end else if (oe_q && tick_i) begin
      sh_q <= {sh_q[WORD_W-2:0], 1'b0};
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sd_o   = oe_q & sh_q[WORD_W-1];
  assign oe_o   = oe_q;
  assign done_o = oe_q & tick_i & (cnt_q == LAST);
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import cmd_parser_pkg::*;
#(
  parameter logic [CODE_W-1:0] ACK_CODE  = 8'hA5,
  parameter logic [CODE_W-1:0] NACK_CODE = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              sup_i,
  input  logic              short_i,
  input  logic              exec_done_i,
  input  logic              shift_done_i,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_sop_o,
  output logic              cmd_eop_o,
  output logic [OP_W-1:0]   cmd_opcode_o,
  output logic              load_o,
  output logic [WORD_W-1:0] resp_o
);
  frame_st_e        st_q;
  logic [LEN_W-1:0] remain_q;
  logic [OP_W-1:0]  op_q;

  assign load_o = (st_q == ST_HDR && rx_valid_i && !sup_i) ||
                  (st_q == ST_WAIT && exec_done_i);
  assign resp_o = (st_q == ST_HDR) ? make_resp(NACK_CODE, op_i)
                                   : make_resp(ACK_CODE, op_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_HDR;
      remain_q    <= '0;
      op_q        <= '0;
      cmd_valid_o <= 1'b0;
      cmd_word_o  <= '0;
      cmd_sop_o   <= 1'b0;
      cmd_eop_o   <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      unique case (st_q)
        ST_HDR: if (rx_valid_i) begin
          if (!sup_i) begin
            st_q <= ST_RESP;
          end else begin
            op_q        <= op_i;
            cmd_valid_o <= 1'b1;
            cmd_word_o  <= rx_word_i;
            cmd_sop_o   <= 1'b1;
            cmd_eop_o   <= short_i;
            remain_q    <= short_i ? '0 : len_i - 1'b1;
            st_q        <= short_i ? ST_WAIT : ST_DATA;
          end
        end
        ST_DATA: if (rx_valid_i) begin
          cmd_valid_o <= 1'b1;
          cmd_word_o  <= rx_word_i;
          cmd_sop_o   <= 1'b0;
          cmd_eop_o   <= (remain_q == LEN_W'(1));
          remain_q    <= remain_q - 1'b1;
          if (remain_q == LEN_W'(1)) st_q <= ST_WAIT;
        end
        ST_WAIT: if (exec_done_i) st_q <= ST_RESP;
        ST_RESP: if (shift_done_i) st_q <= ST_HDR;
        default: st_q <= ST_HDR;
      endcase
    end
  end

  assign cmd_opcode_o = op_q;
endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
  import cmd_parser_pkg::*;
#(
  parameter logic [NUM_OPS-1:0] SUP_MASK  = 16'h80FE,
  parameter logic [CODE_W-1:0]  ACK_CODE  = 8'hA5,
  parameter logic [CODE_W-1:0]  NACK_CODE = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_sop_o,
  output logic              cmd_eop_o,
  output logic [OP_W-1:0]   cmd_opcode_o,
  input  logic              exec_done_i,
  input  logic              bit_tick_i,
  output logic              sd_o,
  output logic              sd_oe_o
);
  logic [OP_W-1:0]   op;
  logic [LEN_W-1:0]  len;
  logic              sup, short_len, load, shift_done;
  logic [WORD_W-1:0] resp;

  hdr_decode #(.SUP_MASK(SUP_MASK)) u_dec (
    .word_i (rx_word_i),
    .op_o   (op),
    .len_o  (len),
    .sup_o  (sup),
    .short_o(short_len)
  );

  frame_ctrl #(.ACK_CODE(ACK_CODE), .NACK_CODE(NACK_CODE)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_word_i   (rx_word_i),
    .op_i        (op),
    .len_i       (len),
    .sup_i       (sup),
    .short_i     (short_len),
    .exec_done_i (exec_done_i),
    .shift_done_i(shift_done),
    .cmd_valid_o (cmd_valid_o),
    .cmd_word_o  (cmd_word_o),
    .cmd_sop_o   (cmd_sop_o),
    .cmd_eop_o   (cmd_eop_o),
    .cmd_opcode_o(cmd_opcode_o),
    .load_o      (load),
    .resp_o      (resp)
  );

  resp_shifter u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .word_i(resp),
    .tick_i(bit_tick_i),
    .sd_o  (sd_o),
    .oe_o  (sd_oe_o),
    .done_o(shift_done)
  );
endmodule

// File: rtl/cmd_frame_parser_chk.sv
module cmd_frame_parser_chk
  import cmd_parser_pkg::*;
#(
  parameter logic [NUM_OPS-1:0] SUP_MASK = 16'h80FE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic [WORD_W-1:0] cmd_word_o,
  input logic              cmd_sop_o,
  input logic              cmd_eop_o,
  input logic [OP_W-1:0]   cmd_opcode_o,
  input logic              bit_tick_i,
  input logic              sd_o,
  input logic              sd_oe_o
);
  a_r1_sop_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_sop_o) |-> cmd_opcode_o == cmd_word_o[WORD_W-1 -: OP_W]);

  a_r3_short_is_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_sop_o && cmd_word_o[LEN_W-1:0] <= LEN_W'(1)) |-> cmd_eop_o);

  a_r4_only_supported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> SUP_MASK[cmd_opcode_o]);

  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o && !bit_tick_i) |=> (sd_oe_o && $stable(sd_o)));

  a_r8_no_words_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> !cmd_valid_o);
endmodule

bind cmd_frame_parser cmd_frame_parser_chk #(.SUP_MASK(SUP_MASK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_word_o  (cmd_word_o),
  .cmd_sop_o   (cmd_sop_o),
  .cmd_eop_o   (cmd_eop_o),
  .cmd_opcode_o(cmd_opcode_o),
  .bit_tick_i  (bit_tick_i),
  .sd_o        (sd_o),
  .sd_oe_o     (sd_oe_o)
);

// File: tb/cmd_frame_parser_tb.sv
module cmd_frame_parser_tb;
  localparam logic [15:0] SUP  = 16'h80FE;
  localparam logic [7:0]  ACK  = 8'hA5;
  localparam logic [7:0]  NACK = 8'h5A;

  typedef struct packed {
    logic [15:0] w;
    logic        sop;
    logic        eop;
    logic [3:0]  op;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, exec_done = 1'b0, tick = 1'b0;
  logic [15:0] rx_word = '0;
  logic cmd_valid, cmd_sop, cmd_eop, sd, sd_oe;
  logic [15:0] cmd_word;
  logic [3:0] cmd_op;

  int checks = 0, failures = 0;
  bit finished = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  cmd_frame_parser #(.SUP_MASK(SUP), .ACK_CODE(ACK), .NACK_CODE(NACK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_word_i(rx_word),
    .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word), .cmd_sop_o(cmd_sop),
    .cmd_eop_o(cmd_eop), .cmd_opcode_o(cmd_op), .exec_done_i(exec_done),
    .bit_tick_i(tick), .sd_o(sd), .sd_oe_o(sd_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && cmd_valid) begin
    exp_t got, e;
    got = '{w: cmd_word, sop: cmd_sop, eop: cmd_eop, op: cmd_op};
    if (q.size() == 0) begin
      check(1'b0, "R8 unexpected word", got, 0);
    end else begin
      e = q.pop_front();
      check(got == e, "R1/R2/R3 frame item", got, e);
    end
  end

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_word  = w;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // header plus ndata words; expectations pushed only for supported opcodes
  task automatic send_cmd(input logic [3:0] op, input logic [11:0] len, input int ndata);
    logic [15:0] hdr;
    hdr = {op, len};
    if (SUP[op]) begin
      q.push_back('{w: hdr, sop: 1'b1, eop: (len <= 1), op: op});
      for (int i = 1; i <= ndata; i++)
        q.push_back('{w: {op, 12'(i)}, sop: 1'b0, eop: (i == int'(len) - 1), op: op});
    end
    send_word(hdr);
    for (int i = 1; i <= ndata; i++) send_word({op, 12'(i)});
  endtask

  task automatic read_resp(input logic [15:0] exp, input string req);
    logic [15:0] got;
    check(sd_oe == 1'b1, "R6 line driven", sd_oe, 1);
    for (int i = 15; i >= 0; i--) begin
      got[i] = sd;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
    check(got == exp, req, got, exp);
    check(sd_oe == 1'b0, "R6 line released after 16 bits", sd_oe, 0);
  endtask

  task automatic finish_cmd(input logic [3:0] op);
    repeat (4) @(negedge clk);
    check(sd_oe == 1'b0, "R7 held until done", sd_oe, 0);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    read_resp({ACK, 4'h0, op}, "R5 ACK word");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_valid == 1'b0, "R9 reset valid", cmd_valid, 0);
    check(sd_oe == 1'b0, "R9 reset line", sd_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: length 3, then a stray word while busy (R8)
    send_cmd(4'h3, 12'd3, 2);
    send_word(16'hDEAD);
    finish_cmd(4'h3);

    // R3: length 0 and 1; R8 next word is a header
    send_cmd(4'h5, 12'd0, 0);
    finish_cmd(4'h5);
    send_cmd(4'hF, 12'd1, 0);
    finish_cmd(4'hF);

    // R4: unsupported opcode 9, word during response dropped
    send_cmd(4'h9, 12'd4, 0);
    check(sd_oe == 1'b1, "R4 immediate NACK", sd_oe, 1);
    send_word(16'h1234);
    read_resp({NACK, 4'h0, 4'h9}, "R4/R5 NACK word");

    // R4: opcode 0, then R8 resumes on header
    send_cmd(4'h0, 12'd2, 0);
    read_resp({NACK, 4'h0, 4'h0}, "R4/R5 NACK word op0");

    // R7: stray done in idle is ignored
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    send_cmd(4'h1, 12'd6, 5);
    finish_cmd(4'h1);

    send_cmd(4'h7, 12'd2, 1);
    finish_cmd(4'h7);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 all items seen", q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule